// File: doc/BRIEF.md
# Ethernet PHY Management Register Bank

This block holds the 16-bit management registers of an Ethernet PHY. A management-frame engine reaches them through a synchronous single-port interface. That interface carries a 5-bit register number, a write strobe, a read strobe and 16-bit data. Each register number has its own access policy:
- A few registers store write data.
- Several are read-only, and return reset constants or live state.
- Unimplemented and unmapped numbers read as zero and ignore writes.
- Some registers have side effects.

A live link-status input drives two bits. A live bit inside the vendor-specific status register follows the link. The link bit of the basic status register is latched low. It drops at once when the link is lost, and it only picks up the live state after the basic status register has been read. The 1000BASE-T status register always reads a fixed pattern. A control write with the reset bit set stores nothing and raises a one-cycle soft-reset request. The active-low reset input is the hard reset and loads every register with its power-on value.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After hard reset the registers read as follows:
  - control (address 0) reads 0x1140: bit 6 speed MSB, bit 8 full duplex, bit 12 auto-negotiation enable.
  - status (1) reads 0x7969.
  - advertisement (4) reads 0x01E1.
  - partner ability (5) reads 0x01E0.
  - gigabit control (9) reads 0x1E00.
  - vendor control (16) reads 0x0068.
  - vendor status (17) reads 0x0000 while the link is down.
- R2: Address 2 reads 0x0141. Address 3 reads the value on `ext_id_i`.
- R3: Writes to addresses 0 (with bit 15 clear), 4 and 16 store the full 16-bit write data. A later read of that address returns it.
- R4: Writes to addresses 1, 2, 3, 5, 9, 10 and 17 leave every readable register unchanged.
- R5: Reads of unimplemented addresses (6, 7, 8, 15, 18–21, 26, 29, 30) and of unmapped addresses return 0. Writes to them change no readable register.
- R6: A write to address 0 with bit 15 set does not change the control register. It makes `soft_reset_req_o` high for exactly the one cycle after the write strobe.
- R7: A read of address 10 always returns 0x3C00.
- R8: Bit 2 of the status register (address 1) is latched low:
  - A status read returns the latched value, then reloads the latch from the live link bit.
  - While `link_up_i` is low the latched bit is cleared.
  - A rising link never sets it without a status read.
- R9: Bit 10 of the vendor status register (address 17) equals `link_up_i` delayed by one clock. All its other bits read 0.
- R10: `rdata_o` is updated on the clock edge that samples `rd_en_i` and holds its value while no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| ext_id_i | input | 16 | Extended identifier returned at address 3 |
| link_up_i | input | 1 | Live link state from the line side |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 5 | Register number |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, registered |
| soft_reset_req_o | output | 1 | One-cycle soft-reset request |

## Verification
The assertions assume three things about the inputs:
- `rd_en_i` and `wr_en_i` are never high in the same cycle.
- `ext_id_i` is held steady during operation.
- Both strobes are low while reset is asserted.

The sequencing tasks drive a single strobe per access, on the falling edge, and drop it before the next access. Link transitions are applied with idle cycles around them, so no status read overlaps the cycle in which the live bit is still catching up.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  localparam int DW = 16;
  localparam int AW = 5;

  // register numbers whose behaviour differs
  localparam logic [AW-1:0] A_CTRL   = 5'd0;
  localparam logic [AW-1:0] A_STAT   = 5'd1;
  localparam logic [AW-1:0] A_ID     = 5'd2;
  localparam logic [AW-1:0] A_EXTID  = 5'd3;
  localparam logic [AW-1:0] A_ADV    = 5'd4;
  localparam logic [AW-1:0] A_PARTN  = 5'd5;
  localparam logic [AW-1:0] A_GCTRL  = 5'd9;
  localparam logic [AW-1:0] A_GSTAT  = 5'd10;
  localparam logic [AW-1:0] A_VCTRL  = 5'd16;
  localparam logic [AW-1:0] A_VSTAT  = 5'd17;

  localparam logic [DW-1:0] RST_CTRL  = 16'h1140;
  localparam logic [DW-1:0] STAT_BASE = 16'h7969;
  localparam logic [DW-1:0] ID_VALUE  = 16'h0141;
  localparam logic [DW-1:0] RST_ADV   = 16'h01E1;
  localparam logic [DW-1:0] PARTN_VAL = 16'h01E0;
  localparam logic [DW-1:0] GCTRL_VAL = 16'h1E00;
  localparam logic [DW-1:0] GSTAT_VAL = 16'h3C00;
  localparam logic [DW-1:0] RST_VCTRL = 16'h0068;

  localparam int CTRL_RST_BIT  = 15;
  localparam int STAT_LINK_BIT = 2;
  localparam int VSTAT_LINK_BIT = 10;

  typedef enum logic [1:0] {
    K_ABSENT,   // unmapped or unimplemented: reads 0, writes dropped
    K_STORE,    // write data stored
    K_FIXED     // read-only
  } reg_kind_e;

  function automatic reg_kind_e kind_of(input logic [AW-1:0] a);
    case (a)
      A_CTRL, A_ADV, A_VCTRL: return K_STORE;
      A_STAT, A_ID, A_EXTID, A_PARTN, A_GCTRL, A_GSTAT, A_VSTAT: return K_FIXED;
      default: return K_ABSENT;
    endcase
  endfunction

  function automatic logic [DW-1:0] stat_word(input logic latched);
    logic [DW-1:0] w;
    w = STAT_BASE;
    w[STAT_LINK_BIT] = latched;
    return w;
  endfunction

  function automatic logic [DW-1:0] vstat_word(input logic live);
    logic [DW-1:0] w;
    w = '0;
    w[VSTAT_LINK_BIT] = live;
    return w;
  endfunction

endpackage

// File: rtl/phy_access_decode.sv
module phy_access_decode
  import phy_mgmt_pkg::*;
(
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          wr_ctrl_o,
  output logic          wr_adv_o,
  output logic          wr_vctrl_o,
  output logic          soft_hit_o,
  output logic          stat_rd_o
);
  reg_kind_e kind;
  logic      store_wr;

  always_comb begin
    kind       = kind_of(addr_i);
    store_wr   = wr_en_i && (kind == K_STORE);
    soft_hit_o = store_wr && (addr_i == A_CTRL) && wdata_i[CTRL_RST_BIT];
    wr_ctrl_o  = store_wr && (addr_i == A_CTRL) && !wdata_i[CTRL_RST_BIT];
    wr_adv_o   = store_wr && (addr_i == A_ADV);
    wr_vctrl_o = store_wr && (addr_i == A_VCTRL);
    stat_rd_o  = rd_en_i && (addr_i == A_STAT);
  end
endmodule

// File: rtl/phy_link_track.sv
module phy_link_track (
  input  logic clk,
  input  logic rst_n,
  input  logic link_up_i,
  input  logic stat_rd_i,
  output logic live_o,
  output logic latched_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_o    <= 1'b0;
      latched_o <= 1'b0;
    end else begin
      live_o <= link_up_i;
      if (!link_up_i)      latched_o <= 1'b0;
      else if (stat_rd_i)  latched_o <= live_o;
    end
  end

  // R8
  latched_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latched_o) |-> $past(stat_rd_i));
  // R8
  down_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up_i |=> !latched_o);
  // R9
  live_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> live_o == $past(link_up_i));
endmodule

// File: rtl/phy_store_regs.sv
module phy_store_regs
  import phy_mgmt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl_i,
  input  logic          wr_adv_i,
  input  logic          wr_vctrl_i,
  input  logic          soft_hit_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] adv_o,
  output logic [DW-1:0] vctrl_o,
  output logic          soft_req_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o     <= RST_CTRL;
      adv_o      <= RST_ADV;
      vctrl_o    <= RST_VCTRL;
      soft_req_o <= 1'b0;
    end else begin
      if (wr_ctrl_i)  ctrl_o  <= wdata_i;
      if (wr_adv_i)   adv_o   <= wdata_i;
      if (wr_vctrl_i) vctrl_o <= wdata_i;
      soft_req_o <= soft_hit_i;
    end
  end

  // R6
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_hit_i |=> $stable(ctrl_o) && soft_req_o);
  // R6
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_ctrl_i, wr_adv_i, wr_vctrl_i, soft_hit_i}));
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] ext_id_i,
  input  logic          link_up_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          soft_reset_req_o
);
  logic          wr_ctrl, wr_adv, wr_vctrl, soft_hit, stat_rd;
  logic          live, latched;
  logic [DW-1:0] ctrl_q, adv_q, vctrl_q, rd_mux;

  phy_access_decode u_dec (
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_ctrl_o(wr_ctrl), .wr_adv_o(wr_adv), .wr_vctrl_o(wr_vctrl),
    .soft_hit_o(soft_hit), .stat_rd_o(stat_rd)
  );

  phy_link_track u_link (
    .clk(clk), .rst_n(rst_n), .link_up_i(link_up_i), .stat_rd_i(stat_rd),
    .live_o(live), .latched_o(latched)
  );

  phy_store_regs u_store (
    .clk(clk), .rst_n(rst_n), .wr_ctrl_i(wr_ctrl), .wr_adv_i(wr_adv),
    .wr_vctrl_i(wr_vctrl), .soft_hit_i(soft_hit), .wdata_i(wdata_i),
    .ctrl_o(ctrl_q), .adv_o(adv_q), .vctrl_o(vctrl_q), .soft_req_o(soft_reset_req_o)
  );

  always_comb begin
    case (addr_i)
      A_CTRL:  rd_mux = ctrl_q;
      A_STAT:  rd_mux = stat_word(latched);
      A_ID:    rd_mux = ID_VALUE;
      A_EXTID: rd_mux = ext_id_i;
      A_ADV:   rd_mux = adv_q;
      A_PARTN: rd_mux = PARTN_VAL;
      A_GCTRL: rd_mux = GCTRL_VAL;
      A_GSTAT: rd_mux = GSTAT_VAL;
      A_VCTRL: rd_mux = vctrl_q;
      A_VSTAT: rd_mux = vstat_word(live);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rdata_o));
  // R7
  gstat_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == A_GSTAT) |=> rdata_o == 16'h3C00);
  // R4
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && kind_of(addr_i) != K_STORE) |=>
      $stable(ctrl_q) && $stable(adv_q) && $stable(vctrl_q));
  // R5
  absent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && kind_of(addr_i) == K_ABSENT) |=> rdata_o == '0);
endmodule

// File: tb/test_phy_mgmt_regs.sv
module test_phy_mgmt_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ext_id = 16'h0CC2;
  logic        link_up = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        soft_req;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  phy_mgmt_regs i_phy_mgmt_regs (
    .clk(clk), .rst_n(rst_n), .ext_id_i(ext_id), .link_up_i(link_up),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .soft_reset_req_o(soft_req)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %04h expected %04h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d, output logic pulse);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; pulse = soft_req;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    check("R10 rdata at reset", rdata, 16'h0000);
    rd(5'd0, v);  check("R1 ctrl", v, 16'h1140);
    rd(5'd1, v);  check("R1 status", v, 16'h7969);
    rd(5'd4, v);  check("R1 adv", v, 16'h01E1);
    rd(5'd5, v);  check("R1 partner", v, 16'h01E0);
    rd(5'd9, v);  check("R1 gctrl", v, 16'h1E00);
    rd(5'd16, v); check("R1 vctrl", v, 16'h0068);
    rd(5'd17, v); check("R1 vstat", v, 16'h0000);
  endtask

  task automatic t_ident;
    logic [15:0] v;
    rd(5'd2, v); check("R2 id", v, 16'h0141);
    rd(5'd3, v); check("R2 ext id", v, 16'h0CC2);
  endtask

  task automatic t_store;
    logic [15:0] v; logic p;
    wr(5'd0, 16'h2100, p); rd(5'd0, v);  check("R3 ctrl", v, 16'h2100);
    check("R6 no pulse on plain write", {15'd0, p}, 16'h0000);
    wr(5'd4, 16'hA5C3, p); rd(5'd4, v);  check("R3 adv", v, 16'hA5C3);
    wr(5'd16, 16'h7FFE, p); rd(5'd16, v); check("R3 vctrl", v, 16'h7FFE);
  endtask

  task automatic t_readonly;
    logic [15:0] v; logic p;
    logic [4:0] ro [7] = '{5'd1, 5'd2, 5'd3, 5'd5, 5'd9, 5'd10, 5'd17};
    foreach (ro[i]) wr(ro[i], 16'hFFFF, p);
    rd(5'd1, v);  check("R4 status kept", v, 16'h7969);
    rd(5'd2, v);  check("R4 id kept", v, 16'h0141);
    rd(5'd5, v);  check("R4 partner kept", v, 16'h01E0);
    rd(5'd9, v);  check("R4 gctrl kept", v, 16'h1E00);
    rd(5'd17, v); check("R4 vstat kept", v, 16'h0000);
    rd(5'd0, v);  check("R4 ctrl kept", v, 16'h2100);
  endtask

  task automatic t_absent;
    logic [15:0] v; logic p;
    logic [4:0] ab [14] = '{5'd6, 5'd7, 5'd8, 5'd15, 5'd18, 5'd19, 5'd20, 5'd21,
                            5'd26, 5'd29, 5'd30, 5'd11, 5'd25, 5'd31};
    foreach (ab[i]) begin
      wr(ab[i], 16'hBEEF, p);
      rd(ab[i], v); check("R5 absent reads 0", v, 16'h0000);
    end
    rd(5'd4, v);  check("R5 adv untouched", v, 16'hA5C3);
    rd(5'd16, v); check("R5 vctrl untouched", v, 16'h7FFE);
  endtask

  task automatic t_soft;
    logic [15:0] v; logic p;
    wr(5'd0, 16'h8000, p);
    check("R6 pulse after write", {15'd0, p}, 16'h0001);
    @(negedge clk);
    check("R6 pulse one cycle", {15'd0, soft_req}, 16'h0000);
    rd(5'd0, v); check("R6 ctrl unchanged", v, 16'h2100);
  endtask

  task automatic t_gstat;
    logic [15:0] v; logic p;
    wr(5'd10, 16'h0000, p);
    rd(5'd10, v); check("R7 gstat", v, 16'h3C00);
  endtask

  task automatic t_link;
    logic [15:0] v;
    link_up = 1'b1; idle(3);
    rd(5'd17, v); check("R9 live up", v, 16'h0400);
    rd(5'd1, v);  check("R8 latched still low", v, 16'h7969);
    rd(5'd1, v);  check("R8 latched after read", v, 16'h796D);
    rd(5'd1, v);  check("R8 latched stays", v, 16'h796D);
    @(negedge clk); link_up = 1'b0;
    @(negedge clk); link_up = 1'b1; idle(3);
    rd(5'd17, v); check("R9 live back up", v, 16'h0400);
    rd(5'd1, v);  check("R8 drop remembered", v, 16'h7969);
    rd(5'd1, v);  check("R8 refresh", v, 16'h796D);
    link_up = 1'b0; idle(2);
    rd(5'd17, v); check("R9 live down", v, 16'h0000);
    rd(5'd1, v);  check("R8 cleared when down", v, 16'h7969);
  endtask

  task automatic t_hold;
    logic [15:0] v;
    rd(5'd2, v); idle(3);
    check("R10 rdata holds", rdata, 16'h0141);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_ident();
    t_store();
    t_readonly();
    t_absent();
    t_soft();
    t_gstat();
    t_link();
    t_hold();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule